// File: doc/BRIEF.md
# Thread Block Occupancy Dispatcher

This block controls how many thread blocks one compute core may hold at the same time, and it admits new blocks up to that cap. Software or a launch controller sets four static configuration inputs: the per-block demand for threads, shared memory bytes and registers, and a hard limit on block count. For each resource, the block divides the core's fixed capacity (set by parameters) by the per-block demand. The residency cap is the smallest of the four results. A flag vector shows which resources bind that cap.

At run time, block launch requests arrive on a valid/ready handshake. An accepted launch takes the lowest free slot and returns that slot index with the grant. The slot's remaining-thread counter is loaded with the configured threads per block. Thread exit events name a slot and count that slot down. When the last thread of a block exits, the slot is freed and a retire pulse reports it. That slot can be used again from the next cycle.

The launch handshake applies back-pressure only through `launch_ready`. A requester holds `launch_valid` until it sees `launch_valid && launch_ready` at a clock edge. `launch_slot` is meaningful only in that cycle. Exit events have no back-pressure: every cycle with `exit_valid` high is consumed.

Top module: `occ_dispatcher`

## Requirements
- R1: `max_blocks` is the minimum of four values:
  - floor(CORE_THREADS / cfg_threads)
  - floor(CORE_SMEM / cfg_smem)
  - floor(CORE_REGS / cfg_regs)
  - cfg_blk_limit

  Each quotient saturates at 15. A demand of zero counts as 15. The result is registered, so it follows the configuration one clock later.
- R2: `lim_flags` marks every input equal to that minimum: bit 0 threads, bit 1 shared memory, bit 2 registers, bit 3 block limit. On a tie, several bits are set.
- R3: After reset, the outputs are as follows:
  - `max_blocks` = 0 and `lim_flags` = 4'b1000
  - `active_count` = 0
  - `launch_ready` = 0
  - `retire_valid` = 0 and `exit_err` = 0
- R4: `launch_ready` is high exactly when a free slot exists and `active_count` < `max_blocks`. With all 8 slots busy, it is low even if `max_blocks` is larger.
- R5: An accepted launch takes the lowest-numbered free slot, reported on `launch_slot`. `active_count` rises by one after the accepting edge.
- R6: At launch, a slot's counter is loaded with `cfg_threads`. Each exit event on an active slot decrements it. Exits before the last one retire nothing and leave `active_count` unchanged.
- R7: After the edge that takes the last exit of a block:
  - the slot is free;
  - `active_count` is one lower;
  - `retire_valid` is high for one cycle with `retire_slot` naming the slot.
- R8: A slot freed by a final exit cannot be granted in the cycle of that exit. In that cycle `launch_ready` still reflects the slot as busy. It may be granted in the following cycle.
- R9: An exit naming an inactive slot changes no state. `exit_err` is high for the one cycle after it.
- R10: With `cfg_blk_limit` = 2 and free slots remaining, `launch_ready` falls once two blocks are resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_threads | input | 11 | Threads per block |
| cfg_smem | input | 17 | Shared memory bytes per block |
| cfg_regs | input | 17 | Registers per block |
| cfg_blk_limit | input | 4 | Hard cap on resident blocks |
| max_blocks | output | 4 | Computed residency cap |
| lim_flags | output | 4 | Binding resources (threads, smem, regs, limit) |
| launch_valid | input | 1 | Launch request |
| launch_ready | output | 1 | Launch can be accepted |
| launch_slot | output | 3 | Granted slot index |
| exit_valid | input | 1 | Thread exit event |
| exit_slot | input | 3 | Slot of the exiting thread |
| active_count | output | 4 | Resident block count |
| retire_valid | output | 1 | Block retired last cycle |
| retire_slot | output | 3 | Slot of the retired block |
| exit_err | output | 1 | Previous exit named an inactive slot |

## Verification
The bench runs several configurations, and each one makes a different resource bind:
- a single shared-memory limit;
- a two-way tie;
- zero demands with a small block limit;
- a four-way tie at saturation.

A flaw in division, saturation or tie detection shows up as a wrong cap or flag. The bench fills all eight slots while the cap is fifteen, so a design that ignores slot exhaustion keeps granting. It sends the final exit of a block while a launch is pending. A design that reuses the slot in the same cycle grants one cycle early, and a miscounted thread counter retires one exit too soon or too late. An exit to an idle slot must raise the error pulse and leave the count unchanged. A low block limit must stop admission while slots are still free.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int LIM_N = 4;
  typedef enum int { LIM_THR = 0, LIM_SMEM = 1, LIM_REG = 2, LIM_BLK = 3 } lim_e;
endpackage

// File: rtl/occ_quot.sv
// Saturating floor(CAP / demand); zero demand means no constraint.
module occ_quot #(
  parameter int DW  = 11,
  parameter int CAP = 1536,
  parameter int QW  = 4
) (
  input  logic [DW-1:0] demand,
  output logic [QW-1:0] quot
);
  localparam int QMAX = (1 << QW) - 1;
  logic [31:0] raw;

  always_comb begin
    raw = 32'd0;
    if (demand == '0) begin
      quot = QMAX[QW-1:0];
    end else begin
      raw = 32'(CAP) / 32'(demand);
      quot = (raw > 32'(QMAX)) ? QMAX[QW-1:0] : raw[QW-1:0];
    end
  end
endmodule

// File: rtl/occ_limit.sv
// Registered minimum over the per-resource limits, with tie-aware flags.
module occ_limit
  import occ_pkg::*;
#(
  parameter int QW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [QW-1:0]     q_in [LIM_N],
  output logic [QW-1:0]     max_blocks,
  output logic [LIM_N-1:0]  lim_flags
);
  logic [QW-1:0]    mn;
  logic [LIM_N-1:0] flags_c;

  always_comb begin
    mn = q_in[0];
    for (int i = 1; i < LIM_N; i++)
      if (q_in[i] < mn) mn = q_in[i];
  end

  for (genvar g = 0; g < LIM_N; g++) begin : g_flag
    assign flags_c[g] = (q_in[g] == mn);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      max_blocks <= '0;
      lim_flags  <= LIM_N'(1) << LIM_BLK;
    end else begin
      max_blocks <= mn;
      lim_flags  <= flags_c;
    end
  end
endmodule

// File: rtl/occ_slots.sv
// Slot table: per-slot active bit and remaining-thread counter.
module occ_slots #(
  parameter int SLOTS = 8,
  parameter int SW    = 3,
  parameter int TW    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [TW-1:0]    alloc_threads,
  input  logic             exit_valid,
  input  logic [SW-1:0]    exit_slot,
  output logic             free_found,
  output logic [SW-1:0]    free_idx,
  output logic [SLOTS-1:0] active_mask,
  output logic             fin_now,
  output logic             retire_valid,
  output logic [SW-1:0]    retire_slot,
  output logic             exit_err
);
  logic [TW-1:0] cnt [SLOTS];
  logic          slot_ok;
  logic          hit_active;

  assign slot_ok    = 32'(exit_slot) < SLOTS;
  assign hit_active = exit_valid && slot_ok && active_mask[exit_slot];
  assign fin_now    = hit_active && (cnt[exit_slot] <= TW'(1));

  // Lowest free slot wins.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!active_mask[i]) begin
        free_found = 1'b1;
        free_idx   = SW'(i);
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        active_mask[g] <= 1'b0;
        cnt[g]         <= '0;
      end else if (alloc_en && free_idx == SW'(g)) begin
        active_mask[g] <= 1'b1;
        cnt[g]         <= alloc_threads;
      end else if (hit_active && exit_slot == SW'(g)) begin
        if (cnt[g] <= TW'(1)) active_mask[g] <= 1'b0;
        cnt[g] <= cnt[g] - TW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      retire_valid <= 1'b0;
      retire_slot  <= '0;
      exit_err     <= 1'b0;
    end else begin
      retire_valid <= fin_now;
      if (fin_now) retire_slot <= exit_slot;
      exit_err     <= exit_valid && !hit_active;
    end
  end
endmodule

// File: rtl/occ_dispatcher.sv
module occ_dispatcher
  import occ_pkg::*;
#(
  parameter int MAX_SLOTS    = 8,
  parameter int THR_W        = 11,
  parameter int SMEM_W       = 17,
  parameter int REG_W        = 17,
  parameter int CORE_THREADS = 1536,
  parameter int CORE_SMEM    = 49152,
  parameter int CORE_REGS    = 32768,
  localparam int SLOT_W      = $clog2(MAX_SLOTS),
  localparam int CNT_W       = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [THR_W-1:0]  cfg_threads,
  input  logic [SMEM_W-1:0] cfg_smem,
  input  logic [REG_W-1:0]  cfg_regs,
  input  logic [CNT_W-1:0]  cfg_blk_limit,
  output logic [CNT_W-1:0]  max_blocks,
  output logic [LIM_N-1:0]  lim_flags,
  input  logic              launch_valid,
  output logic              launch_ready,
  output logic [SLOT_W-1:0] launch_slot,
  input  logic              exit_valid,
  input  logic [SLOT_W-1:0] exit_slot,
  output logic [CNT_W-1:0]  active_count,
  output logic              retire_valid,
  output logic [SLOT_W-1:0] retire_slot,
  output logic              exit_err
);
  logic [CNT_W-1:0]     q [LIM_N];
  logic                 free_found;
  logic [SLOT_W-1:0]    free_idx;
  logic [MAX_SLOTS-1:0] slot_active;
  logic                 fin_now;
  logic                 accept;

  occ_quot #(.DW(THR_W),  .CAP(CORE_THREADS), .QW(CNT_W)) u_q_thr (.demand(cfg_threads), .quot(q[LIM_THR]));
  occ_quot #(.DW(SMEM_W), .CAP(CORE_SMEM),    .QW(CNT_W)) u_q_smem(.demand(cfg_smem),    .quot(q[LIM_SMEM]));
  occ_quot #(.DW(REG_W),  .CAP(CORE_REGS),    .QW(CNT_W)) u_q_reg (.demand(cfg_regs),    .quot(q[LIM_REG]));
  assign q[LIM_BLK] = cfg_blk_limit;

  occ_limit #(.QW(CNT_W)) u_limit (
    .clk(clk), .rst(rst), .q_in(q),
    .max_blocks(max_blocks), .lim_flags(lim_flags)
  );

  assign launch_ready = free_found && (active_count < max_blocks);
  assign accept       = launch_valid && launch_ready;
  assign launch_slot  = free_idx;

  occ_slots #(.SLOTS(MAX_SLOTS), .SW(SLOT_W), .TW(THR_W)) u_slots (
    .clk(clk), .rst(rst),
    .alloc_en(accept), .alloc_threads(cfg_threads),
    .exit_valid(exit_valid), .exit_slot(exit_slot),
    .free_found(free_found), .free_idx(free_idx),
    .active_mask(slot_active), .fin_now(fin_now),
    .retire_valid(retire_valid), .retire_slot(retire_slot),
    .exit_err(exit_err)
  );

  always_ff @(posedge clk) begin
    if (rst) active_count <= '0;
    else     active_count <= active_count + CNT_W'(accept) - CNT_W'(fin_now);
  end
endmodule

// File: rtl/occ_dispatcher_chk.sv
module occ_dispatcher_chk #(
  parameter int SLOTS = 8,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [SLOTS-1:0] slot_active,
  input logic [CW-1:0]    active_count,
  input logic [CW-1:0]    max_blocks,
  input logic [3:0]       lim_flags,
  input logic             launch_valid,
  input logic             launch_ready,
  input logic             exit_valid,
  input logic             retire_valid,
  input logic             exit_err
);
  // R5/R7: the resident counter tracks the slot table
  p_count_match_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_active) == 32'(active_count));
  // R4: no grant beyond the cap
  p_ready_cap_r4: assert property (@(posedge clk) disable iff (rst)
    launch_ready |-> (active_count < max_blocks));
  // R5: an accepted launch without an exit adds one block
  p_launch_inc_r5: assert property (@(posedge clk) disable iff (rst)
    (launch_valid && launch_ready && !exit_valid) |=> active_count == $past(active_count) + CW'(1));
  // R7: retire only follows an exit
  p_retire_cause_r7: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> $past(exit_valid));
  // R9: error and retire never refer to the same exit
  p_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
    exit_err |-> !retire_valid);
  // R2: some limit always binds
  p_flags_set_r2: assert property (@(posedge clk) disable iff (rst)
    lim_flags != 4'b0000);
endmodule

bind occ_dispatcher occ_dispatcher_chk #(.SLOTS(MAX_SLOTS), .CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .slot_active(slot_active), .active_count(active_count),
  .max_blocks(max_blocks), .lim_flags(lim_flags), .launch_valid(launch_valid),
  .launch_ready(launch_ready), .exit_valid(exit_valid),
  .retire_valid(retire_valid), .exit_err(exit_err)
);

// File: tb/occ_dispatcher_test.sv
module occ_dispatcher_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] cfg_threads = '0;
  logic [16:0] cfg_smem = '0;
  logic [16:0] cfg_regs = '0;
  logic [3:0]  cfg_blk_limit = '0;
  logic [3:0]  max_blocks, lim_flags, active_count;
  logic        launch_valid = 1'b0, launch_ready;
  logic [2:0]  launch_slot, retire_slot;
  logic        exit_valid = 1'b0;
  logic [2:0]  exit_slot = '0;
  logic        retire_valid, exit_err;

  int checks = 0;
  int fails  = 0;
  int exp_grant[$];
  int exp_retire[$];

  always #2.5 clk = ~clk;

  occ_dispatcher uut (
    .clk(clk), .rst(rst), .cfg_threads(cfg_threads), .cfg_smem(cfg_smem),
    .cfg_regs(cfg_regs), .cfg_blk_limit(cfg_blk_limit), .max_blocks(max_blocks),
    .lim_flags(lim_flags), .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_slot(launch_slot), .exit_valid(exit_valid), .exit_slot(exit_slot),
    .active_count(active_count), .retire_valid(retire_valid),
    .retire_slot(retire_slot), .exit_err(exit_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compare grants and retirements against the scoreboard queues.
  always @(negedge clk) begin
    if (!rst && launch_valid && launch_ready) begin
      if (exp_grant.size() == 0) chk("R5 unexpected grant", int'(launch_slot), -1);
      else chk("R5 grant slot", int'(launch_slot), exp_grant.pop_front());
    end
    if (!rst && retire_valid) begin
      if (exp_retire.size() == 0) chk("R7 unexpected retire", int'(retire_slot), -1);
      else chk("R7 retire slot", int'(retire_slot), exp_retire.pop_front());
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic configure(input int t, input int s, input int r, input int b,
                           input int exp_max, input int exp_flags, input string tag);
    cyc();
    cfg_threads = 11'(t); cfg_smem = 17'(s); cfg_regs = 17'(r); cfg_blk_limit = 4'(b);
    cyc(); cyc();
    @(negedge clk);
    chk({"R1 max ", tag}, int'(max_blocks), exp_max);
    chk({"R2 flags ", tag}, int'(lim_flags), exp_flags);
  endtask

  task automatic launch(input int slot);
    cyc();
    exp_grant.push_back(slot);
    launch_valid = 1'b1;
    cyc();
    launch_valid = 1'b0;
  endtask

  task automatic thread_exit(input int slot, input bit last);
    cyc();
    if (last) exp_retire.push_back(slot);
    exit_valid = 1'b1; exit_slot = 3'(slot);
    cyc();
    exit_valid = 1'b0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst = 1'b0;
    @(negedge clk);
    chk("R3 max", int'(max_blocks), 0);
    chk("R3 flags", int'(lim_flags), 8);
    chk("R3 active", int'(active_count), 0);
    chk("R3 ready", int'(launch_ready), 0);
    chk("R3 retire", int'(retire_valid), 0);
    chk("R3 err", int'(exit_err), 0);

    configure(256, 16384, 8192, 8, 3, 4'b0010, "smem");
    configure(512, 16384, 0, 5, 3, 4'b0011, "tie");
    configure(0, 0, 0, 2, 2, 4'b1000, "zero");
    configure(4, 0, 0, 15, 15, 4'b1111, "sat");

    for (int i = 0; i < 8; i++) launch(i);
    @(negedge clk);
    chk("R5 active after 8", int'(active_count), 8);
    chk("R4 slots full ready", int'(launch_ready), 0);

    for (int i = 0; i < 3; i++) thread_exit(2, 1'b0);
    @(negedge clk);
    chk("R6 no early retire", int'(active_count), 8);

    // Final exit of slot 2 with a pending launch in the same cycle.
    cyc();
    exp_retire.push_back(2);
    exp_grant.push_back(2);
    exit_valid = 1'b1; exit_slot = 3'd2; launch_valid = 1'b1;
    @(negedge clk);
    chk("R8 ready in exit cycle", int'(launch_ready), 0);
    cyc();
    exit_valid = 1'b0;
    @(negedge clk);
    chk("R7 active after final exit", int'(active_count), 7);
    chk("R8 ready next cycle", int'(launch_ready), 1);
    cyc();
    launch_valid = 1'b0;
    @(negedge clk);
    chk("R5 active after refill", int'(active_count), 8);

    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++) thread_exit(s, k == 3);
    cyc();
    @(negedge clk);
    chk("R7 all retired", int'(active_count), 0);

    cyc();
    exit_valid = 1'b1; exit_slot = 3'd5;
    cyc();
    exit_valid = 1'b0;
    @(negedge clk);
    chk("R9 err pulse", int'(exit_err), 1);
    chk("R9 active unchanged", int'(active_count), 0);
    cyc();
    @(negedge clk);
    chk("R9 err clears", int'(exit_err), 0);

    configure(4, 0, 0, 2, 2, 4'b1000, "cap2");
    launch(0);
    launch(1);
    @(negedge clk);
    chk("R10 active at cap", int'(active_count), 2);
    chk("R10 ready at cap", int'(launch_ready), 0);

    cyc(); cyc();
    chk("R5 grants drained", exp_grant.size(), 0);
    chk("R7 retires drained", exp_retire.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule